// File: doc/BRIEF.md
# Two-Wire Command Slave

This block is the device end of a two-wire serial bus with one clock line and one shared data line. It watches the bus for START and STOP, takes an address byte, and answers only when the 7-bit address matches one of two fixed values picked by a strap input. A write transaction leaves up to eight bytes in a command buffer: a command byte followed by up to seven arguments. A single-cycle strobe hands the buffer to the command executor when the bus STOP arrives. A read transaction sends bytes from a response buffer of up to sixteen bytes, starting with a status byte.

Both bus lines are sampled by a faster system clock through two-stage synchronisers. Edges are detected after the synchronisers. The data output works like an open-drain pin: an enable pulls the line low, and the line is released otherwise. The block does not execute commands and never stretches the clock.

Top module: `cmd_link_slave`

## Requirements
- R1: START is the data line falling while the clock is high. STOP is the data line rising while the clock is high. A START seen in the middle of a transaction (repeated START) restarts address reception and discards any write bytes collected since the previous START.
- R2: The first byte after START is received most significant bit first, with each bit captured on a rising clock edge. It holds the 7-bit address followed by a direction bit (1 = read, 0 = write).
- R3: The address is 7'b0010001 when `addr_strap` is 0 and 7'b1100011 when it is 1. On a mismatch the block sends no acknowledge and keeps the line released until the next START or STOP.
- R4: The block acknowledges a matching address byte, and each accepted write byte, by holding the data line low for the ninth bit period. It asserts `sda_oe` after the falling clock edge that ends the eighth bit and releases it after the next falling edge.
- R5: Write bytes are stored in arrival order. Byte 0 is the command and appears at `cmd_data[7:0]`; byte k appears at `cmd_data[8k+7:8k]`. At most 8 bytes are accepted. A ninth byte gets no acknowledge and is dropped, and the line stays released until START or STOP.
- R6: One system clock after a STOP is detected, `cmd_valid` pulses high for exactly one cycle, with `cmd_len` equal to the number of accepted bytes. This happens only if that count is at least 1. A STOP after an address-only write, after a read, or after a mismatched address gives no pulse.
- R7: On a read, bytes come from `rsp_data`, starting with byte 0 (bits 7:0, the status byte) and continuing with byte k at bits 8k+7:8k. Each byte is sent most significant bit first. The data line changes only after falling clock edges, and a 0 bit is driven low while a 1 bit is released.
- R8: When the master leaves the data line high in the acknowledge slot after a read byte, the block releases the line and waits for START or STOP. After the sixteenth byte is sent, the block releases the line, so any further byte reads as all ones.
- R9: `sda_oe` is the only bus output. It is low after reset and never changes while the synchronised clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level, as seen on the wire |
| addr_strap | input | 1 | Selects which of the two device addresses is used |
| rsp_data | input | 128 | Response bytes; byte 0 (status) in bits 7:0 |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cmd_valid | output | 1 | Single-cycle strobe that the command buffer is complete |
| cmd_len | output | 4 | Number of valid bytes in `cmd_data` when strobed |
| cmd_data | output | 64 | Command byte in bits 7:0, then the arguments |

## Verification
Any fault in the bit counter, the state machine or the address compare shows up at `sda_oe` within one bus bit. It appears as an acknowledge in the wrong slot, a missing acknowledge, or a read bit with the wrong level. Comparing `sda_oe` on every system clock outside a short settling window after each falling edge therefore catches such faults before the byte ends. A wrong byte count or a wrong buffer position is only visible at the STOP strobe. So each transaction ends with a check of the pulse count, the length and every stored byte.

// File: rtl/cmd_link_slave.sv
module cmd_link_slave #(
  parameter int CMD_MAX = 8,
  parameter int RSP_MAX = 16,
  parameter logic [6:0] ADDR_LO = 7'b0010001,
  parameter logic [6:0] ADDR_HI = 7'b1100011
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_in,
  input  logic                   sda_in,
  input  logic                   addr_strap,
  input  logic [RSP_MAX*8-1:0]   rsp_data,
  output logic                   sda_oe,
  output logic                   cmd_valid,
  output logic [$clog2(CMD_MAX+1)-1:0] cmd_len,
  output logic [CMD_MAX*8-1:0]   cmd_data
);
  localparam int CW = $clog2(CMD_MAX + 1);
  localparam int RW = $clog2(RSP_MAX);
  localparam logic [CW-1:0] CMAX  = CW'(CMD_MAX);
  localparam logic [RW-1:0] RLAST = RW'(RSP_MAX - 1);

  typedef enum logic [3:0] {IDLE, ADDR, ADDR_END, ACK, WR, WR_END, RD, RACK, IGN} st_t;

  st_t st;
  logic [2:0] scl_p, sda_p;
  logic [2:0] cnt;
  logic [7:0] sh;
  logic       rw, nack;
  logic [CW-1:0] wcnt;
  logic [RW-1:0] ridx;

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire sda       = sda_p[1];
  wire start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire [6:0] my_addr = addr_strap ? ADDR_HI : ADDR_LO;
  wire [RW-1:0] ridx_n = ridx + RW'(1);
  wire [7:0] first_byte = rsp_data[{ridx, 3'b000} +: 8];
  wire [7:0] next_byte  = rsp_data[{ridx_n, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      cnt <= '0;
      sh <= '0;
      rw <= 1'b0;
      nack <= 1'b0;
      wcnt <= '0;
      ridx <= '0;
      sda_oe <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_len <= '0;
      cmd_data <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start_det) begin
        st <= ADDR;
        cnt <= '0;
        wcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= IDLE;
        sda_oe <= 1'b0;
        wcnt <= '0;
        if (wcnt != '0) begin
          cmd_valid <= 1'b1;
          cmd_len <= wcnt;
        end
      end else begin
        case (st)
          ADDR, WR: if (scl_rise) begin
            sh <= {sh[6:0], sda};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) st <= (st == ADDR) ? ADDR_END : WR_END;
          end
          ADDR_END: if (scl_fall) begin
            if (sh[7:1] == my_addr) begin
              sda_oe <= 1'b1;
              rw <= sh[0];
              ridx <= '0;
              st <= ACK;
            end else st <= IGN;
          end
          ACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              sh <= first_byte;
              sda_oe <= ~first_byte[7];
              st <= RD;
            end else begin
              sda_oe <= 1'b0;
              st <= WR;
            end
          end
          WR_END: if (scl_fall) begin
            if (wcnt < CMAX) begin
              cmd_data[{wcnt, 3'b000} +: 8] <= sh;
              wcnt <= wcnt + CW'(1);
              sda_oe <= 1'b1;
              st <= ACK;
            end else st <= IGN;
          end
          RD: if (scl_fall) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st <= RACK;
            end else begin
              sh <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
          RACK: if (scl_rise) nack <= sda;
                else if (scl_fall) begin
            if (nack || ridx == RLAST) st <= IGN;
            else begin
              ridx <= ridx_n;
              cnt <= '0;
              sh <= next_byte;
              sda_oe <= ~next_byte[7];
              st <= RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ADDR && cnt == 3'd0 && wcnt == '0)); // R1
  AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_p[1]); // R9
  AST_WRITE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CMAX); // R5
  AST_STROBE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(stop_det)); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R6
  AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IGN || st == IDLE) |-> !sda_oe); // R8
endmodule

// File: tb/cmd_link_slave_test.sv
`timescale 1ns/1ps
module cmd_link_slave_test;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [127:0] rsp;
  logic sda_oe, cmd_valid;
  logic [3:0] cmd_len;
  logic [63:0] cmd_data;
  wire sda_line = sda_m & ~sda_oe;

  int checks = 0, fails = 0, guard = 0, pulses = 0, exp_pulses = 0, last_len = 0;
  logic [63:0] last_data = '0;
  bit exp_oe = 1'b0, mon_en = 1'b0, done = 1'b0;
  string cur_req = "R9";

  always #2.5 clk = ~clk;

  cmd_link_slave uut (.clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .addr_strap(strap), .rsp_data(rsp), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
    .cmd_len(cmd_len), .cmd_data(cmd_data));

  always @(negedge clk) begin
    if (mon_en) begin
      if (guard > 0) guard--;
      else begin
        checks++;
        if (sda_oe !== exp_oe) begin
          fails++;
          $display("FAIL %s: sda_oe actual %b expected %b at %0t", cur_req, sda_oe, exp_oe, $time);
        end
      end
    end
    if (cmd_valid === 1'b1) begin
      pulses++;
      last_len = cmd_len;
      last_data = cmd_data;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic slot(input bit b, input bit e, output bit got);
    exp_oe = e; guard = 6;
    tick(2); sda_m = b;
    tick(Q); scl_m = 1'b1;
    tick(Q); got = sda_line;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic start_c();
    exp_oe = 1'b0; guard = 6;
    tick(2); sda_m = 1'b1;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b0;
    tick(Q); scl_m = 1'b0;
  endtask

  task automatic stop_c();
    exp_oe = 1'b0; guard = 6;
    tick(2); sda_m = 1'b0;
    tick(Q); scl_m = 1'b1;
    tick(Q); sda_m = 1'b1;
    tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input bit ack_exp, input string req);
    bit g;
    for (int i = 7; i >= 0; i--) slot(v[i], 1'b0, g);
    slot(1'b1, ack_exp, g);
    chk(req, {63'd0, g}, {63'd0, !ack_exp});
  endtask

  task automatic rd_byte(input logic [7:0] exp, input bit mack, input string req);
    bit g;
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, ~exp[i], g);
      got[i] = g;
    end
    slot(!mack, 1'b0, g);
    chk(req, {56'd0, got}, {56'd0, exp});
  endtask

  function automatic logic [7:0] rb(input int k);
    return rsp[k*8 +: 8];
  endfunction

  task automatic chk_cmd(input string req, input int len, input logic [63:0] bytes);
    chk(req, 64'(pulses), 64'(exp_pulses));
    chk(req, 64'(last_len), 64'(len));
    for (int i = 0; i < len; i++) chk(req, {56'd0, last_data[i*8 +: 8]}, {56'd0, bytes[i*8 +: 8]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] wv;
    for (int i = 0; i < 16; i++) rsp[i*8 +: 8] = 8'(8'h3C ^ (i * 8'h1D) ^ (i << 4));
    tick(5);
    chk("R9", {63'd0, sda_oe}, 64'd0);
    chk("R6", {63'd0, cmd_valid}, 64'd0);
    rst_n = 1'b1;
    tick(4);
    mon_en = 1'b1;

    // R2 R3 R4 R5 R6: basic write, strap 0
    cur_req = "R4"; strap = 1'b0;
    start_c(); wr_byte(8'h22, 1'b1, "R3");
    wr_byte(8'hA5, 1'b1, "R4"); wr_byte(8'h01, 1'b1, "R4"); wr_byte(8'h7E, 1'b1, "R5");
    stop_c(); exp_pulses++;
    chk_cmd("R5", 3, 64'h0000_0000_007E_01A5);

    // R3: wrong address ignored, no strobe
    cur_req = "R3";
    start_c(); wr_byte(8'hC6, 1'b0, "R3"); wr_byte(8'h55, 1'b0, "R3");
    stop_c();
    chk("R6", 64'(pulses), 64'(exp_pulses));

    // R5: strap 1, ten bytes, last two dropped
    cur_req = "R5"; strap = 1'b1;
    wv = 64'h8877_6655_4433_2211;
    start_c(); wr_byte(8'hC6, 1'b1, "R3");
    for (int i = 0; i < 8; i++) wr_byte(wv[i*8 +: 8], 1'b1, "R5");
    wr_byte(8'h99, 1'b0, "R5"); wr_byte(8'hAA, 1'b0, "R5");
    stop_c(); exp_pulses++;
    chk_cmd("R5", 8, wv);

    // R7 R8: read with master nack, then released
    cur_req = "R7";
    start_c(); wr_byte(8'hC7, 1'b1, "R7");
    rd_byte(rb(0), 1'b1, "R7"); rd_byte(rb(1), 1'b1, "R7"); rd_byte(rb(2), 1'b0, "R8");
    cur_req = "R8";
    rd_byte(8'hFF, 1'b0, "R8");
    stop_c();
    chk("R6", 64'(pulses), 64'(exp_pulses));

    // R8: full 16-byte read, 17th released
    cur_req = "R7";
    start_c(); wr_byte(8'hC7, 1'b1, "R7");
    for (int i = 0; i < 16; i++) rd_byte(rb(i), 1'b1, "R7");
    cur_req = "R8";
    rd_byte(8'hFF, 1'b0, "R8");
    stop_c();

    // R1: repeated START discards write bytes
    cur_req = "R1"; strap = 1'b0;
    start_c(); wr_byte(8'h22, 1'b1, "R1"); wr_byte(8'h10, 1'b1, "R1"); wr_byte(8'h20, 1'b1, "R1");
    start_c(); wr_byte(8'h23, 1'b1, "R1"); rd_byte(rb(0), 1'b0, "R1");
    stop_c();
    chk("R1", 64'(pulses), 64'(exp_pulses));

    // R6: address-only write gives no strobe
    cur_req = "R6";
    start_c(); wr_byte(8'h22, 1'b1, "R6"); stop_c();
    chk("R6", 64'(pulses), 64'(exp_pulses));

    // R3 R1: mismatch ignored until repeated START, then accepted
    cur_req = "R3";
    start_c(); wr_byte(8'hC6, 1'b0, "R3");
    start_c(); wr_byte(8'h22, 1'b1, "R1"); wr_byte(8'h5A, 1'b1, "R4");
    stop_c(); exp_pulses++;
    chk_cmd("R6", 1, 64'h5A);

    tick(10);
    mon_en = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule